// File: doc/BRIEF.md
# Event Performance Counter Unit

This block counts activity for a processor core. It has one free-running cycle counter and two event counters. Each event counter watches one line of a vector of single-cycle event pulses. An 8-bit code held in the control register picks that line. A single control/status register holds the global enable, the clear strobes, a slow cycle-count mode, the interrupt enables, the overflow flags and both event codes. Software reaches that register and the three counters through a small register port with an address, a write enable, write data and combinational read data.

A counter overflows when it steps from all ones to zero. The overflow sets a sticky flag for that counter. Software clears each flag on its own by writing a 1 to it. The interrupt output is raised while any flag is set and its enable bit is on. An interrupt handler can stop the unit, read the flags, write the same value back to clear them, and then start the unit again.

Top module: `evt_perf_unit`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is low.
- R2: Control bit 0 is the global enable. While it is 0, no counter advances. While it is 1 and bit 3 is 0, the cycle counter (address 1) adds one on every clock.
- R3: Event counter 0 (address 2) takes its code from control bits 19:12. Event counter 1 (address 3) takes its code from bits 27:20. A code N below the number of event lines adds one for each enabled clock in which `evt_i[N]` is high. Code 0xFF, and any code at or above the line count, never counts.
- R4: Writing 1 to control bit 1 clears both event counters. Writing 1 to control bit 2 clears the cycle counter and its divider. A clear takes priority over counting in the same clock. Both bits always read 0.
- R5: When control bit 3 is 1, the cycle counter adds one once every 64 enabled clocks. The first step comes on the 64th enabled clock after a cycle-counter clear.
- R6: A write to address 1, 2 or 3 loads that counter directly. The load takes priority over an increment in the same clock.
- R7: Flag bits 8, 9 and 10 belong to event counter 0, event counter 1 and the cycle counter. Each flag is set when its counter wraps from 0xFFFFFFFF to 0. A set flag stays set when other counters overflow. Writing 1 to a flag bit clears only that flag. Writing 0 leaves it alone.
- R8: Bits 4, 5 and 6 enable the interrupt for event counter 0, event counter 1 and the cycle counter. `irq_o` is high exactly while some flag is set together with its enable bit.
- R9: Control bits 1, 2, 7, 11 and 31:28 always read 0. Writing all ones to the control register reads back as 0x0FFFF079.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_i | input | EVT_LINES | Single-cycle event pulses, one per line |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions assume that the register port and the event lines change only away from the rising edge, and that `reg_addr` is always a defined value. They also assume that the only way a counter value changes without an increment is a write from the register port. The bench drives every input on the falling edge and idles `reg_we` low between single-cycle writes, so each write or stall lands on one known edge. Counts are planned in whole clock edges so that the expected values fall out of the write schedule alone.

// File: rtl/epc_pkg.sv
package epc_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned CODE_W   = 8;
   localparam int unsigned NCNT     = 3;   // index 0: event 0, 1: event 1, 2: cycle

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_CYC  = 2'd1,
      RA_EV0  = 2'd2,
      RA_EV1  = 2'd3
   } epc_addr_e;

   localparam int unsigned B_EN    = 0;
   localparam int unsigned B_EVCLR = 1;
   localparam int unsigned B_CYCLR = 2;
   localparam int unsigned B_DIV   = 3;
   localparam int unsigned B_IE    = 4;   // 3 bits: ev0, ev1, cycle
   localparam int unsigned B_OVF   = 8;   // 3 bits: ev0, ev1, cycle
   localparam int unsigned B_SEL0  = 12;
   localparam int unsigned B_SEL1  = 20;

   localparam logic [REG_W-1:0] RD_ZERO_MASK = 32'hF000_0886;
endpackage

// File: rtl/epc_counter.sv
module epc_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (ld)     cnt_q <= ld_val;
      else if (inc)    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = inc & ~clr & ~ld & (&cnt_q);
endmodule

// File: rtl/epc_evt_sel.sv
module epc_evt_sel #(
   parameter int unsigned LINES  = 23,
   parameter int unsigned CODE_W = 8
) (
   input  logic [CODE_W-1:0] code,
   input  logic [LINES-1:0]  evt,
   output logic              hit_o
);
   always_comb begin
      hit_o = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         if (code == CODE_W'(i)) hit_o = evt[i];
      end
   end
endmodule

// File: rtl/epc_prescale.sv
module epc_prescale #(
   parameter int unsigned DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic tick_o
);
   logic [DIV_LOG2-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (clr)  pre_q <= '0;
      else if (adv)  pre_q <= pre_q + 1'b1;
   end

   assign tick_o = adv & ~clr & (&pre_q);
endmodule

// File: rtl/evt_perf_unit.sv
module evt_perf_unit
   import epc_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned EVT_LINES = 23,
   parameter int unsigned DIV_LOG2  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           reg_addr,
   input  logic                 reg_we,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic [EVT_LINES-1:0] evt_i,
   output logic                 irq_o
);
   localparam int unsigned IDX_CYC = NCNT - 1;

   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 2..32");
   end
   if (EVT_LINES < 1 || EVT_LINES > 255) begin : g_bad_lines
      $error("EVT_LINES must lie in 1..255, code 0xFF is reserved");
   end
   if (DIV_LOG2 < 1 || DIV_LOG2 > 16) begin : g_bad_div
      $error("DIV_LOG2 must lie in 1..16");
   end

   logic                en_q, div_q;
   logic [NCNT-1:0]     ie_q, ovf_q;
   logic [CODE_W-1:0]   sel_q [2];

   logic                wr_ctrl;
   logic [NCNT-1:0]     clr, ld, inc, wrap;
   logic [CNT_W-1:0]    cnt [NCNT];
   logic [1:0]          hit;
   logic                tick;
   logic                unused_wbits;

   assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
   assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

   // control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         div_q    <= 1'b0;
         ie_q     <= '0;
         sel_q[0] <= '0;
         sel_q[1] <= '0;
      end else if (wr_ctrl) begin
         en_q     <= reg_wdata[B_EN];
         div_q    <= reg_wdata[B_DIV];
         ie_q     <= reg_wdata[B_IE +: NCNT];
         sel_q[0] <= reg_wdata[B_SEL0 +: CODE_W];
         sel_q[1] <= reg_wdata[B_SEL1 +: CODE_W];
      end
   end

   // sticky overflow flags, write-one-to-clear, a new wrap wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= (ovf_q & ~(wr_ctrl ? reg_wdata[B_OVF +: NCNT] : '0)) | wrap;
   end

   // event selection, one mux per event counter
   for (genvar e = 0; e < 2; e++) begin : g_sel
      epc_evt_sel #(.LINES(EVT_LINES), .CODE_W(CODE_W)) u_sel (
         .code  (sel_q[e]),
         .evt   (evt_i),
         .hit_o (hit[e])
      );
   end

   epc_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr[IDX_CYC]),
      .adv    (en_q & div_q),
      .tick_o (tick)
   );

   // per-counter controls and instances
   for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      if (c == IDX_CYC) begin : g_cyc
         assign clr[c] = wr_ctrl & reg_wdata[B_CYCLR];
         assign ld[c]  = reg_we && (reg_addr == RA_CYC);
         assign inc[c] = en_q & (div_q ? tick : 1'b1);
      end else begin : g_evt
         assign clr[c] = wr_ctrl & reg_wdata[B_EVCLR];
         assign ld[c]  = reg_we && (reg_addr == 2'(RA_EV0 + c));
         assign inc[c] = en_q & hit[c];
      end
      epc_counter #(.W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr[c]),
         .ld     (ld[c]),
         .ld_val (reg_wdata[CNT_W-1:0]),
         .inc    (inc[c]),
         .cnt_o  (cnt[c]),
         .wrap_o (wrap[c])
      );
   end

   // read path
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[B_EN]              = en_q;
            reg_rdata[B_DIV]             = div_q;
            reg_rdata[B_IE +: NCNT]      = ie_q;
            reg_rdata[B_OVF +: NCNT]     = ovf_q;
            reg_rdata[B_SEL0 +: CODE_W]  = sel_q[0];
            reg_rdata[B_SEL1 +: CODE_W]  = sel_q[1];
         end
         RA_CYC:  reg_rdata[CNT_W-1:0] = cnt[IDX_CYC];
         RA_EV0:  reg_rdata[CNT_W-1:0] = cnt[0];
         default: reg_rdata[CNT_W-1:0] = cnt[1];
      endcase
   end

   assign irq_o = |(ovf_q & ie_q);
endmodule

// File: rtl/evt_perf_unit_chk.sv
module evt_perf_unit_chk
   import epc_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_addr,
   input logic             reg_we,
   input logic [REG_W-1:0] reg_rdata,
   input logic             en,
   input logic             div,
   input logic [NCNT-1:0]  ovf,
   input logic [CNT_W-1:0] cyc_cnt,
   input logic [CNT_W-1:0] ev0_cnt,
   input logic             irq_o
);
   // R2: with the unit off and no write, nothing moves
   a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reg_we) |=> ($stable(cyc_cnt) && $stable(ev0_cnt)));

   // R7: flags only fall through a control write
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == RA_CTRL) |=> ((ovf & $past(ovf)) == $past(ovf)));

   // R7: a cycle wrap in plain mode raises the cycle flag
   a_r7_cyc_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !div && !reg_we && (&cyc_cnt)) |=> ovf[2]);

   // R8: no interrupt without a pending flag
   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ovf != '0));

   // R9: reserved and strobe bits read as zero
   a_r9_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_CTRL) |-> ((reg_rdata & RD_ZERO_MASK) == '0));
endmodule

bind evt_perf_unit evt_perf_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_rdata (reg_rdata),
   .en        (en_q),
   .div       (div_q),
   .ovf       (ovf_q),
   .cyc_cnt   (cnt[2]),
   .ev0_cnt   (cnt[0]),
   .irq_o     (irq_o)
);

// File: tb/evt_perf_unit_bench.sv
module evt_perf_unit_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned LINES = 23;
   localparam logic [31:0] EN = 32'h1, EVC = 32'h2, CYC = 32'h4, DIV = 32'h8;
   localparam logic [31:0] IE0 = 32'h10, IE1 = 32'h20, IEC = 32'h40;
   localparam logic [31:0] F0 = 32'h100, F1 = 32'h200, FC = 32'h400;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       reg_addr = '0;
   logic             reg_we = 1'b0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [LINES-1:0] evt_i = '0;
   logic             irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evt_perf_unit u_evt_perf_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_i     (evt_i),
      .irq_o     (irq_o)
   );

   function automatic logic [31:0] sel(input logic [7:0] c0, input logic [7:0] c1);
      return {4'h0, c1, c0, 12'h000};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk);
      #1 reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [LINES-1:0] v, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         evt_i = v;
      end
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check("R1 reset value", d, 32'h0);
      end
      check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      wr(2'd0, sel(8'd0, 8'd1));
      pulse(LINES'(3), 5);
      rd(2'd2, d); check("R2 ev0 frozen", d, 32'h0);
      rd(2'd3, d); check("R2 ev1 frozen", d, 32'h0);
      rd(2'd1, d); check("R2 cycle frozen", d, 32'h0);
   endtask

   task automatic t_cycle();
      logic [31:0] d;
      wr(2'd0, EN | EVC | CYC | sel(8'd0, 8'd1));
      repeat (9) @(posedge clk);
      wr(2'd0, sel(8'd0, 8'd1));
      rd(2'd1, d); check("R2 cycle counts every clock", d, 32'd10);
      rd(2'd0, d); check("R4 strobes read zero", d, sel(8'd0, 8'd1));
   endtask

   task automatic t_events();
      logic [31:0] d;
      wr(2'd0, EN | sel(8'd3, 8'd5));
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         evt_i = (LINES'(1) << 3) | (LINES'(1) << 4) | ((k >= 4) ? (LINES'(1) << 5) : '0);
      end
      @(negedge clk); evt_i = '0;
      wr(2'd0, sel(8'd3, 8'd5));
      rd(2'd2, d); check("R3 ev0 line 3 count", d, 32'd7);
      rd(2'd3, d); check("R3 ev1 line 5 count", d, 32'd3);
   endtask

   task automatic t_none();
      logic [31:0] d;
      wr(2'd0, EN | EVC | sel(8'hFF, 8'h20));
      pulse('1, 6);
      wr(2'd0, sel(8'hFF, 8'h20));
      rd(2'd2, d); check("R3 code 0xFF never counts", d, 32'h0);
      rd(2'd3, d); check("R3 code beyond lines never counts", d, 32'h0);
   endtask

   task automatic t_load_clear();
      logic [31:0] d;
      wr(2'd0, 32'h0);
      wr(2'd2, 32'h55); wr(2'd3, 32'h66); wr(2'd1, 32'h77);
      rd(2'd2, d); check("R6 load ev0", d, 32'h55);
      rd(2'd3, d); check("R6 load ev1", d, 32'h66);
      rd(2'd1, d); check("R6 load cycle", d, 32'h77);
      wr(2'd0, EVC);
      rd(2'd2, d); check("R4 event clear ev0", d, 32'h0);
      rd(2'd3, d); check("R4 event clear ev1", d, 32'h0);
      rd(2'd1, d); check("R4 event clear spares cycle", d, 32'h77);
      wr(2'd0, CYC);
      rd(2'd1, d); check("R4 cycle clear", d, 32'h0);
      wr(2'd0, EN | sel(8'd2, 8'hFF));
      evt_i = LINES'(1) << 2;
      wr(2'd2, 32'h100);
      @(negedge clk); evt_i = '0;
      wr(2'd0, sel(8'd2, 8'hFF));
      rd(2'd2, d); check("R6 load beats increment", d, 32'h100);
   endtask

   task automatic t_overflow();
      logic [31:0] d;
      wr(2'd0, EN | IE0 | sel(8'd3, 8'd5));
      wr(2'd2, 32'hFFFF_FFFF);
      pulse(LINES'(1) << 3, 1);
      rd(2'd2, d); check("R7 ev0 wraps to zero", d, 32'h0);
      rd(2'd0, d); check("R7 ev0 flag set", d & 32'h700, 32'h100);
      check("R8 irq on ev0 flag", {31'h0, irq_o}, 32'h1);
      wr(2'd3, 32'hFFFF_FFFF);
      pulse(LINES'(1) << 5, 1);
      rd(2'd0, d); check("R7 earlier flag kept", d & 32'h700, 32'h300);
      wr(2'd0, EN | IE0 | F0 | sel(8'd3, 8'd5));
      rd(2'd0, d); check("R7 clear only flag 0", d & 32'h700, 32'h200);
      check("R8 masked ev1 flag", {31'h0, irq_o}, 32'h0);
      wr(2'd0, EN | IE1 | sel(8'd3, 8'd5));
      check("R8 irq on ev1 enable", {31'h0, irq_o}, 32'h1);
      wr(2'd0, F1 | sel(8'd3, 8'd5));
      rd(2'd0, d); check("R7 all flags cleared", d & 32'h700, 32'h0);
      check("R8 irq drops", {31'h0, irq_o}, 32'h0);
   endtask

   task automatic t_cyc_overflow();
      logic [31:0] d;
      wr(2'd1, 32'hFFFF_FFFD);
      wr(2'd0, EN | IEC);
      repeat (5) @(posedge clk);
      rd(2'd0, d); check("R7 cycle flag", d & 32'h700, 32'h400);
      check("R8 irq on cycle flag", {31'h0, irq_o}, 32'h1);
      wr(2'd0, FC);
      rd(2'd0, d); check("R7 cycle flag cleared", d & 32'h700, 32'h0);
   endtask

   task automatic t_divide();
      logic [31:0] d;
      wr(2'd0, EN | DIV | CYC);
      repeat (62) @(posedge clk);
      wr(2'd0, 32'h0);
      rd(2'd1, d); check("R5 no step before 64th clock", d, 32'd0);
      wr(2'd0, EN | DIV | CYC);
      repeat (63) @(posedge clk);
      wr(2'd0, 32'h0);
      rd(2'd1, d); check("R5 step at 64th clock", d, 32'd1);
      wr(2'd0, EN | DIV | CYC);
      repeat (127) @(posedge clk);
      wr(2'd0, 32'h0);
      rd(2'd1, d); check("R5 two steps in 128 clocks", d, 32'd2);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R9 all-ones readback", d, 32'h0FFF_F079);
      wr(2'd0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_disabled();
      t_cycle();
      t_events();
      t_none();
      t_load_clear();
      t_overflow();
      t_cyc_overflow();
      t_divide();
      t_mask();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule